// File: doc/BRIEF.md
# Receive signal quality flag

This block watches the running mean-squared-error figure produced by a receiver's decision stage and turns it into one quality bit for the host. A two-bit select field picks one of four comparison levels, each matching a target bit error rate. While the error stays at or under the chosen level, the flag stays low. While it sits above the level, the flag blinks: it flips once every fixed interval, which is 1.66 ms at the intended clock. Once the receiver reports that it has lost convergence, the flag is held high until a retrain completes.

The flag is meaningful only when the receiver runs one of its phase-modulated modes, either the differential phase-shift mode or the quadrature-amplitude mode. In every other mode the output is forced low and the internal state is cleared. The four comparison constants and the length of the blink interval in clock cycles are parameters. This lets an integrator scale the MSE units and derive the interval from the system clock frequency.

Top module: `sqi_flag`

## Requirements
- R1: While `rst_n` is low, `sqi` is 0. After reset is released, the blink phase and the sticky state start cleared.
- R2: In an active mode with no loss reported, an `mse` at or under the selected level keeps `sqi` at 0 on every cycle.
- R3: `thr_sel` picks the level as follows. Code 2'b00 (the default) selects `THR_E5` (1e-5). Code 2'b01 selects `THR_E6` (1e-6). Code 2'b10 selects `THR_E4` (1e-4). Code 2'b11 selects `THR_E3` (1e-3). The error counts as over the level only when `mse` is strictly greater than it.
- R4: When `mse` goes over the level in an active mode with no loss reported, `sqi` goes to 1 after the next rising clock edge. After that it inverts once every `TOGGLE_TICKS` cycles for as long as the error stays over the level.
- R5: When `mse` falls back to or under the level and no loss is reported, `sqi` returns to 0 after the next rising edge. This is well within one blink interval.
- R6: When `conv_lost` is sampled high in an active mode, `sqi` is 1 from the next edge on. It stays at 1 on every cycle, whatever `mse` does, until the sticky state is cleared.
- R7: When `retrain_done` is sampled high, the sticky state clears, and this takes priority over a `conv_lost` in the same cycle. From then on, `sqi` follows R2 to R5 again.
- R8: `rx_mode` 2'b01 (differential phase-shift) and 2'b10 (quadrature-amplitude) are the active modes. With 2'b00 or 2'b11, `sqi` is 0 in the same cycle. The blink counter and the sticky state are also cleared, and `conv_lost` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_mode | input | 2 | Receive mode; 01 and 10 enable the flag |
| thr_sel | input | 2 | Error-rate level select |
| mse | input | MSE_W | Running mean-squared error from the decision stage |
| conv_lost | input | 1 | Receiver reports loss of convergence |
| retrain_done | input | 1 | Retrain finished; clears the sticky state |
| sqi | output | 1 | Quality flag: 0 good, blinking marginal, steady 1 lost |

## Verification
The bench runs a sweep over every mode code and every select code. For each pair it applies error values one under, at and one over the selected level, plus zero and full scale. Below, at and above the level separate the strict comparison and the per-code constant from a neighbouring one. Across the four modes, only the two active codes should ever produce a pattern. Over three blink intervals the bench predicts the waveform arithmetically from the cycle index, which separates a wrong period or phase from a wrong level. Directed sequences then cover a drop back under the level, loss of convergence held across changing error values, retrain clearing (including a clear and a loss in the same cycle), and a loss reported or stored while the mode is inactive.

// File: rtl/sqi_flag.sv
module sqi_flag #(
  parameter int MSE_W        = 16,
  parameter int THR_E6       = 256,
  parameter int THR_E5       = 512,
  parameter int THR_E4       = 1024,
  parameter int THR_E3       = 2048,
  parameter int TOGGLE_TICKS = 332000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       rx_mode,
  input  logic [1:0]       thr_sel,
  input  logic [MSE_W-1:0] mse,
  input  logic             conv_lost,
  input  logic             retrain_done,
  output logic             sqi
);
  localparam int CW = (TOGGLE_TICKS > 1) ? $clog2(TOGGLE_TICKS) : 1;
  localparam logic [CW-1:0] LAST = CW'(TOGGLE_TICKS - 1);

  logic [MSE_W-1:0] thr;
  logic [CW-1:0]    cnt_q;
  logic             tog_q, lost_q;
  logic             act, over;

  always_comb begin
    case (thr_sel)
      2'b01:   thr = MSE_W'(THR_E6);
      2'b10:   thr = MSE_W'(THR_E4);
      2'b11:   thr = MSE_W'(THR_E3);
      default: thr = MSE_W'(THR_E5);
    endcase
  end

  assign act  = (rx_mode == 2'b01) || (rx_mode == 2'b10);
  assign over = mse > thr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lost_q <= 1'b0;
      tog_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (!act) begin
      lost_q <= 1'b0;
      tog_q  <= 1'b0;
      cnt_q  <= '0;
    end else begin
      if (retrain_done)   lost_q <= 1'b0;
      else if (conv_lost) lost_q <= 1'b1;
      if (lost_q || !over) begin
        tog_q <= 1'b0;
        cnt_q <= '0;
      end else begin
        if (cnt_q == '0) tog_q <= ~tog_q;
        cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
      end
    end
  end

  assign sqi = act & (lost_q | tog_q);

  // R6
  lost_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && conv_lost && !retrain_done) |=> (!act || sqi));

  // R7
  retrain_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && retrain_done) |=> !lost_q);

  // R5
  drop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !over && !lost_q && !conv_lost) |=> !sqi);

  // R4
  flip_on_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && over && !lost_q && cnt_q == '0) |=> (tog_q != $past(tog_q)));

  // R4
  hold_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (act && over && !lost_q && cnt_q != '0) |=> $stable(tog_q));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  // R8
  idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !act |=> (!lost_q && !tog_q && cnt_q == '0));
endmodule

// File: tb/sqi_flag_tb_top.sv
`timescale 1ns/1ps
module sqi_flag_tb_top;
  localparam int W = 8;
  localparam int TICKS = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [1:0]   rx_mode = 2'b01;
  logic [1:0]   thr_sel = 2'b00;
  logic [W-1:0] mse = '0;
  logic         conv_lost = 1'b0;
  logic         retrain_done = 1'b0;
  logic         sqi;
  int           n_chk = 0;
  int           n_bad = 0;

  always #2.5 clk = ~clk;

  sqi_flag #(.MSE_W(W), .THR_E6(10), .THR_E5(20), .THR_E4(40), .THR_E3(80),
             .TOGGLE_TICKS(TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .rx_mode(rx_mode), .thr_sel(thr_sel), .mse(mse),
    .conv_lost(conv_lost), .retrain_done(retrain_done), .sqi(sqi));

  function automatic int level(input logic [1:0] s);
    case (s)
      2'b00: return 20;
      2'b01: return 10;
      2'b10: return 40;
      default: return 80;
    endcase
  endfunction

  task automatic check(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: sqi=%b expected %b", req, $time, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #200000;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset holds the flag low even with a large error
    mse = 8'd200;
    repeat (3) tick();
    check("R1", sqi, 1'b0);
    mse = '0;
    rst_n = 1'b1;
    tick();
    check("R1", sqi, 1'b0);

    // R2 R3 R4 R8: sweep over mode, select and error value
    for (int m = 0; m < 4; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int v = 0; v < 5; v++) begin
          int lv, val;
          logic act, ov;
          lv = level(2'(s));
          case (v)
            0: val = lv - 1;
            1: val = lv;
            2: val = lv + 1;
            3: val = 0;
            default: val = 255;
          endcase
          rx_mode = 2'b01; mse = '0;
          tick();
          rx_mode = 2'(m); thr_sel = 2'(s); mse = W'(val);
          act = (m == 1) || (m == 2);
          ov = val > lv;
          #0.5;
          check("R8", sqi, 1'b0);
          for (int k = 1; k <= 3*TICKS; k++) begin
            logic e;
            tick();
            e = act && ov && (((k-1)/TICKS) % 2 == 0);
            if (!act) check("R8", sqi, e);
            else if (!ov) check("R2", sqi, e);
            else if (k <= TICKS) check("R3", sqi, e);
            else check("R4", sqi, e);
          end
        end
      end
    end

    // R5: back under the level clears on the next edge
    rx_mode = 2'b10; thr_sel = 2'b11; mse = 8'd81;
    tick(); tick();
    check("R4", sqi, 1'b1);
    mse = 8'd80;
    tick();
    check("R5", sqi, 1'b0);
    tick();
    check("R5", sqi, 1'b0);

    // R6: loss of convergence sticks high across error changes
    mse = 8'd100;
    tick();
    conv_lost = 1'b1;
    tick();
    conv_lost = 1'b0;
    check("R6", sqi, 1'b1);
    for (int k = 0; k < 3*TICKS; k++) begin
      mse = (k % 2 == 0) ? 8'd0 : 8'd250;
      tick();
      check("R6", sqi, 1'b1);
    end

    // R7: retrain clears; with low error flag goes low
    mse = 8'd0;
    retrain_done = 1'b1;
    tick();
    retrain_done = 1'b0;
    tick();
    check("R7", sqi, 1'b0);
    // R7: loss and retrain together -> retrain wins
    conv_lost = 1'b1;
    tick();
    check("R6", sqi, 1'b1);
    retrain_done = 1'b1;
    tick();
    conv_lost = 1'b0; retrain_done = 1'b0;
    tick();
    check("R7", sqi, 1'b0);
    // R7: after clearing, blinking resumes when over the level
    mse = 8'd200;
    tick();
    check("R7", sqi, 1'b1);
    for (int k = 0; k < TICKS; k++) tick();
    check("R7", sqi, 1'b0);

    // R8: inactive mode forces low at once and clears the sticky state
    mse = 8'd0;
    conv_lost = 1'b1;
    tick();
    conv_lost = 1'b0;
    check("R6", sqi, 1'b1);
    rx_mode = 2'b00;
    #0.5;
    check("R8", sqi, 1'b0);
    tick();
    rx_mode = 2'b10;
    #0.5;
    check("R8", sqi, 1'b0);
    tick();
    check("R8", sqi, 1'b0);
    // R8: loss reported while inactive is ignored
    rx_mode = 2'b11;
    conv_lost = 1'b1;
    tick();
    conv_lost = 1'b0;
    rx_mode = 2'b01;
    for (int k = 0; k < 3; k++) begin
      tick();
      check("R8", sqi, 1'b0);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule